// File: doc/BRIEF.md
# Banked RAM/ROM Window Decoder

This block sits on the 16-bit address bus of an 8-bit processor. It turns each bus cycle into chip selects and upper address bits for an expansion board. The board carries an 8K static RAM window and a banked ROM region, and both sit in the top half of the address space. Addresses below the midpoint belong to on-board memory and I/O, so the block leaves them alone.

The ROM device holds 64K. A mode input chooses how the processor sees it. In the wide mode there are two 32K banks, and each shows 24K: its lowest 8K is covered by the RAM window. In the narrow mode there are four 16K banks, and each appears at the top 16K of the address map. Two level inputs choose the bank. Each reads high when its switch is open, which selects the upper bank, and reads low when the switch is closed. Two jumper inputs pick one of four 8K pages of a 32K RAM. A separate input marks an 8K RAM part, whose RAM A13 pin is really a second chip enable and must be held high.

All outputs are registered. Each one reflects the bus inputs sampled at the previous rising clock edge.

Top module: `mw_decoder_top`

## Requirements
- R1: The RAM is selected (`ram_ce_n` low) only when address bits [15:13] equal 3'b100, which is addresses 0x8000–0x9FFF.
- R2: In mode 0 (two 32K banks), the ROM is selected (`rom_ce_n` low) for addresses 0xA000–0xFFFF, which is bits [15:13] from 3'b101 to 3'b111.
- R3: In mode 1 (four 16K banks), the ROM is selected only for addresses 0xC000–0xFFFF, which is bits [15:14] equal 2'b11. Addresses 0xA000–0xBFFF select nothing in this mode.
- R4: An address with bit 15 low asserts neither `ram_ce_n` nor `rom_ce_n`.
- R5: `ram_we_n` is low only for a RAM-window cycle with `cpu_rnw` low and `bus_strobe` high.
- R6: `rom_oe_n` is low only for a ROM-selected cycle with `cpu_rnw` high.
- R7: In mode 0, `rom_addr_hi[1]` (ROM A15) equals `rom_sel[1]`, and `rom_addr_hi[0]` (ROM A14) equals CPU address bit 14.
- R8: In mode 1, `rom_addr_hi` equals `rom_sel`, with bit 1 as ROM A15 and bit 0 as ROM A14. A select input held high picks the upper bank.
- R9: `ram_addr_hi` is {`ram_page[1]`, `ram_page[0]`}, with bit 1 as RAM A14 and bit 0 as RAM A13. When `ram_small` is high, bit 0 is forced to 1 whatever `ram_page[0]` is.
- R10: Every output changes one clock after its inputs are sampled. While `rst` is high, all enables read 1 and both address fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Data phase strobe, high while data is valid |
| bank_mode | input | 1 | 0 = two 32K ROM banks, 1 = four 16K ROM banks |
| rom_sel | input | 2 | ROM bank-select levels, high when the switch is open |
| ram_page | input | 2 | RAM 8K page jumpers |
| ram_small | input | 1 | High when an 8K RAM part is fitted |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_addr_hi | output | 2 | ROM A15:A14 |
| ram_addr_hi | output | 2 | RAM A14:A13 |

## Verification
Every output comes from a single register stage, so each result is due exactly one rising edge after the cycle's inputs are driven. The driver changes inputs on the falling edge and queues the expected output set at the same moment. The monitor pops one entry 2 ns after each rising edge, so each comparison uses the register contents that the queued stimulus produced. The reset values are checked separately while `rst` is held high, before the queue starts.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } bank_mode_e;

  typedef struct packed {
    logic ram_hit;
    logic rom_hit;
  } region_t;
endpackage

// File: rtl/mw_region_dec.sv
module mw_region_dec #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 13,
  parameter int RAM_IDX  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              narrow,
  output mw_pkg::region_t   region
);
  localparam int IDX_W   = ADDR_W - WIN_BITS;
  localparam int ROM_LO  = RAM_IDX + 1;
  localparam int ROM_HI  = RAM_IDX + 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:WIN_BITS];

  always_comb begin
    region.ram_hit = (int'(idx) == RAM_IDX);
    if (narrow) region.rom_hit = (int'(idx) >= ROM_HI);
    else        region.rom_hit = (int'(idx) >= ROM_LO);
  end
endmodule

// File: rtl/mw_rom_bank.sv
module mw_rom_bank #(
  parameter int SEL_W = 2
) (
  input  logic             narrow,
  input  logic             cpu_a14,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] hi
);
  always_comb begin
    hi = sel;
    if (!narrow) hi[0] = cpu_a14;
  end
endmodule

// File: rtl/mw_ram_bank.sv
module mw_ram_bank #(
  parameter int PAGE_W = 2
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              small_part,
  output logic [PAGE_W-1:0] hi
);
  always_comb begin
    hi = page;
    if (small_part) hi[0] = 1'b1;
  end
endmodule

// File: rtl/mw_decoder_top.sv
module mw_decoder_top #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 13,
  parameter int RAM_IDX  = 4,
  parameter int SEL_W    = 2,
  parameter int PAGE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic              bus_strobe,
  input  logic              bank_mode,
  input  logic [SEL_W-1:0]  rom_sel,
  input  logic [PAGE_W-1:0] ram_page,
  input  logic              ram_small,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic [SEL_W-1:0]  rom_addr_hi,
  output logic [PAGE_W-1:0] ram_addr_hi
);
  localparam int A14_BIT = WIN_BITS + 1;

  mw_pkg::region_t   region;
  logic              narrow;
  logic [SEL_W-1:0]  rom_hi_d;
  logic [PAGE_W-1:0] ram_hi_d;

  assign narrow = (mw_pkg::bank_mode_e'(bank_mode) == mw_pkg::MODE_NARROW);

  mw_region_dec #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .RAM_IDX(RAM_IDX)) rgn_i (
    .addr(cpu_addr), .narrow(narrow), .region(region));

  mw_rom_bank #(.SEL_W(SEL_W)) rom_i (
    .narrow(narrow), .cpu_a14(cpu_addr[A14_BIT]), .sel(rom_sel), .hi(rom_hi_d));

  mw_ram_bank #(.PAGE_W(PAGE_W)) ram_i (
    .page(ram_page), .small_part(ram_small), .hi(ram_hi_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n    <= 1'b1;
      ram_we_n    <= 1'b1;
      rom_ce_n    <= 1'b1;
      rom_oe_n    <= 1'b1;
      rom_addr_hi <= '0;
      ram_addr_hi <= '0;
    end else begin
      ram_ce_n    <= !region.ram_hit;
      ram_we_n    <= !(region.ram_hit && !cpu_rnw && bus_strobe);
      rom_ce_n    <= !region.rom_hit;
      rom_oe_n    <= !(region.rom_hit && cpu_rnw);
      rom_addr_hi <= rom_hi_d;
      ram_addr_hi <= ram_hi_d;
    end
  end

  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n); // R5
  AST_SINGLE_CE: assert property (@(posedge clk) disable iff (rst)
    !(!ram_ce_n && !rom_ce_n)); // R1
  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> $past(cpu_rnw)); // R6
  AST_LOW_HALF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_addr[ADDR_W-1]) |-> (ram_ce_n && rom_ce_n)); // R4
  AST_SMALL_CE2: assert property (@(posedge clk) disable iff (rst)
    $past(ram_small) |-> ram_addr_hi[0]); // R9
  AST_NARROW_NO_A000: assert property (@(posedge clk) disable iff (rst)
    ($past(bank_mode) && !$past(cpu_addr[A14_BIT])) |-> rom_ce_n); // R3
endmodule

// File: tb/mw_decoder_top_tb_top.sv
module mw_decoder_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rnw = 1'b1;
  logic        bus_strobe = 1'b0;
  logic        bank_mode = 1'b0;
  logic [1:0]  rom_sel = 2'b11;
  logic [1:0]  ram_page = 2'b00;
  logic        ram_small = 1'b0;
  logic        ram_ce_n, ram_we_n, rom_ce_n, rom_oe_n;
  logic [1:0]  rom_addr_hi, ram_addr_hi;

  int total = 0;
  int bad = 0;
  bit stim_done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  mw_decoder_top dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .bus_strobe(bus_strobe), .bank_mode(bank_mode), .rom_sel(rom_sel),
    .ram_page(ram_page), .ram_small(ram_small), .ram_ce_n(ram_ce_n),
    .ram_we_n(ram_we_n), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_addr_hi(rom_addr_hi), .ram_addr_hi(ram_addr_hi));

  // Packed expectation: {ram_ce_n, ram_we_n, rom_ce_n, rom_oe_n, rom_hi[1:0], ram_hi[1:0]}
  function automatic logic [7:0] model(input logic [15:0] a, input logic rnw,
      input logic stb, input logic md, input logic [1:0] sel,
      input logic [1:0] pg, input logic sm);
    logic ram, rom;
    logic [1:0] rh, mh;
    ram = (a[15:13] == 3'b100);
    rom = md ? (a[15:14] == 2'b11) : (a[15:13] >= 3'b101);
    rh  = md ? sel : {sel[1], a[14]};
    mh  = {pg[1], sm ? 1'b1 : pg[0]};
    return {!ram, !(ram && !rnw && stb), !rom, !(rom && rnw), rh, mh};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b addr=%h mode=%b", req, act, exp,
               cpu_addr, bank_mode);
    end
  endtask

  function automatic string tag_of(input logic [7:0] e, input logic [15:0] a);
    if (!a[15]) return "R4";
    if (!e[7]) return "R1/R5/R9";
    if (!e[5]) return "R2/R3/R6/R7/R8";
    return "R3/R10";
  endfunction

  task automatic drive(input logic [15:0] a, input logic rnw, input logic stb,
      input logic md, input logic [1:0] sel, input logic [1:0] pg, input logic sm);
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; bus_strobe = stb; bank_mode = md;
    rom_sel = sel; ram_page = pg; ram_small = sm;
    exp_q.push_back(model(a, rnw, stb, md, sel, pg, sm));
  endtask

  // Monitor: one result per rising edge, sampled 2 ns after it
  logic [15:0] a_hist;
  initial begin
    forever begin
      @(posedge clk);
      a_hist = cpu_addr;
      #2;
      if (!rst && exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tag_of(e, a_hist),
              {ram_ce_n, ram_we_n, rom_ce_n, rom_oe_n, rom_addr_hi, ram_addr_hi}, e);
      end
    end
  end

  initial begin
    // R10: reset state while rst is held, with inputs that would select RAM and write
    cpu_addr = 16'h8123; cpu_rnw = 1'b0; bus_strobe = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R10", {ram_ce_n, ram_we_n, rom_ce_n, rom_oe_n, rom_addr_hi, ram_addr_hi},
          8'b1111_00_00);
    @(negedge clk);
    rst = 1'b0;
    for (int md = 0; md < 2; md++)
      for (int sel = 0; sel < 4; sel++)
        for (int pg = 0; pg < 4; pg++)
          for (int sm = 0; sm < 2; sm++)
            for (int rg = 0; rg < 8; rg++)
              for (int acc = 0; acc < 4; acc++) begin
                logic [15:0] a;
                a = {rg[2:0], 13'(rg * 16'h0457 + acc * 16'h0123)};
                drive(a, acc[0], acc[1], md[0], sel[1:0], pg[1:0], sm[0]);
              end
    // R1/R3 boundaries: window edges
    drive(16'h7FFF, 1'b1, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0);
    drive(16'h8000, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0);
    drive(16'h9FFF, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0);
    drive(16'hA000, 1'b1, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0);
    drive(16'hBFFF, 1'b1, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0);
    drive(16'hC000, 1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0);
    drive(16'hFFFF, 1'b1, 1'b1, 1'b1, 2'b00, 2'b11, 1'b1);
    @(negedge clk);
    @(negedge clk);
    stim_done = 1'b1;
  end

  initial begin
    fork
      wait (stim_done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule